// File: doc/BRIEF.md
# T1 Two-Frame Elastic Store

This block buffers a serial T1 bit stream between the line side and a system backplane. Line bits enter one per `wr_valid` strobe. Backplane bits leave one per `rd_tick` strobe, and that strobe may come in bursts. The store holds two frames of 193 bits, which is 386 bits in all. The read side follows the write side at frame granularity. When it drifts too far in either direction, the read side repairs the stream by slipping one whole frame: it repeats a frame when data runs short, and it drops a frame when the writer laps it. A sticky status flag reports each kind of slip, and a write of one clears it.

The read side runs in one of two modes. In narrow mode it emits 193-bit frames. In wide mode it emits 32 timeslots of 8 bits each. Every fourth timeslot in wide mode is filler made of ones, except that the first bit of timeslot 0 carries the framing bit. The 24 T1 channels fill the remaining timeslots in order. A store-reset pulse parts the two pointers into opposite frames. When the store is disabled, the output follows the input with one register of delay. Frame pulses appear in both cases, but multiframe pulses appear only while the store is enabled.

Both strobes are clock enables of one fast core clock. That clock must run at least as fast as the fastest burst rate.

Top module: `t1_elastic_store`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rd_valid`, `rd_frame_pulse`, `rd_mframe_pulse`, `slip_under` and `slip_over` are 0. After reset, all 386 stored bits read as 0, and the pointers sit as if a store reset had occurred.
- R2: In narrow mode with the store enabled, output frames are 193 bits long. Output bit k of a frame is stored bit k of the current read frame, and frames are read in the order they were written.
- R3: If the writer has not completed a further frame when the reader finishes a frame, the reader repeats the same frame and sets `slip_under`.
- R4: If the writer has completed two or more frames since the reader last changed frame, the reader re-enters its current frame area, which now holds the newest frame. The older pending frame is thereby dropped, and `slip_over` is set.
- R5: A one-cycle `store_rst` puts the write pointer at the start of frame area 0 and the read pointer at the start of frame area 1, with no pending frames. The next output bit is therefore position 0 of area 1.
- R6: In wide mode, output frames are 256 bits long. Timeslots whose number is a multiple of 4 output ones, except bit 0 of timeslot 0, which is stored bit 0 (the framing bit).
- R7: In wide mode, bit b of timeslot t, where t is not a multiple of 4, is stored bit 1 + 8·(t − t/4 − 1) + b of the current read frame.
- R8: With `store_en` low, each `wr_valid` produces `rd_valid` with `rd_bit` equal to `wr_bit` one cycle later. `rd_frame_pulse` marks every 193rd input bit, counted from write position 0, and `rd_mframe_pulse` stays low.
- R9: With the store enabled, `rd_frame_pulse` accompanies output position 0. `rd_mframe_pulse` accompanies position 0 of every 12th frame, starting with the first frame after a store reset.
- R10: The slip flags are sticky. A set event wins over a same-cycle clear, and `clr_under` or `clr_over` clears its flag on the next edge.
- R11: With the store enabled, `rd_valid` is high exactly one cycle after each `rd_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both strobes are enables of it |
| rst_n | input | 1 | Synchronous active-low reset |
| store_en | input | 1 | 1 = buffer through the store, 0 = pass through |
| wide_mode | input | 1 | 0 = 193-bit output frames, 1 = 256-bit output frames |
| store_rst | input | 1 | Pulse that parts the pointers into opposite frames |
| wr_valid | input | 1 | Line bit strobe |
| wr_bit | input | 1 | Line bit |
| rd_tick | input | 1 | Backplane bit strobe |
| clr_under | input | 1 | Write-one-to-clear for the repeat slip flag |
| clr_over | input | 1 | Write-one-to-clear for the drop slip flag |
| rd_valid | output | 1 | Output bit present |
| rd_bit | output | 1 | Output bit |
| rd_frame_pulse | output | 1 | Output frame start |
| rd_mframe_pulse | output | 1 | Output multiframe start |
| slip_under | output | 1 | Sticky: a frame was repeated |
| slip_over | output | 1 | Sticky: a frame was dropped |

## Verification
Every output bit and its pulses are due one edge after the `rd_tick` that selects them, or one edge after the `wr_valid` in pass-through. A slip flag rises on the edge that ends the read frame in which the slip was decided. Pointer placement after `store_rst` becomes visible in the bit selected by the next tick. The bench drives each cycle's inputs 1 ns after an edge and advances its own model by exactly that one cycle. It then compares all outputs 1 ns after the following edge, so each result is sampled in the cycle it is due and never one early.

// File: rtl/t1es_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the T1 two-frame elastic store.
// Assumes 8-bit timeslots and one filler slot in every four on the wide side.
package t1es_pkg;
    localparam int SLOT_BITS   = 8;
    localparam int FILL_PERIOD = 4;

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DROP   = 2'd2
    } slip_e;
endpackage

// File: rtl/t1es_writer.sv
`timescale 1ns/1ps
// Write pointer of the elastic store: walks the two frame areas circularly.
// Assumes wr_valid is a one-cycle strobe per line bit.
module t1es_writer #(
    parameter int FRAME_BITS = 193,
    parameter int AW         = $clog2(2 * FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_rst,
    input  logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic          wr_done,
    output logic          wr_frame_start,
    output logic          wr_slot
);
    localparam int DEPTH = 2 * FRAME_BITS;

    // Decode frame-area boundaries of the current write address.
    always_comb begin
        wr_slot        = (wr_addr >= AW'(FRAME_BITS));
        wr_frame_start = (wr_addr == '0) || (wr_addr == AW'(FRAME_BITS));
        wr_done        = wr_valid && ((wr_addr == AW'(FRAME_BITS - 1)) ||
                                      (wr_addr == AW'(DEPTH - 1)));
    end

    // Advance the write address on each line bit; wrap after both areas.
    always_ff @(posedge clk) begin
        if (!rst_n || store_rst) begin
            wr_addr <= '0;
        end else if (wr_valid) begin
            wr_addr <= (wr_addr == AW'(DEPTH - 1)) ? '0 : wr_addr + AW'(1);
        end
    end
endmodule

// File: rtl/t1es_bitram.sv
`timescale 1ns/1ps
// Two-frame bit store: one write port, one asynchronous read port.
// Assumes the read address is always inside the store.
module t1es_bitram #(
    parameter int FRAME_BITS = 193,
    parameter int AW         = $clog2(2 * FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    localparam int DEPTH = 2 * FRAME_BITS;

    logic [DEPTH-1:0] cells;

    // Store one bit per write strobe; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the addressed bit.
    always_comb rdata = cells[raddr];
endmodule

// File: rtl/t1es_reader.sv
`timescale 1ns/1ps
// Read side: output position counter, frame-level slip decision and
// narrow/wide formatter. Output values are combinational; the top registers them.
// Assumes wide_mode only changes together with a store reset.
module t1es_reader
    import t1es_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int WIDE_SLOTS = 32,
    parameter int MF_FRAMES  = 12,
    parameter int AW         = $clog2(2 * FRAME_BITS),
    parameter int POS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_rst,
    input  logic             wide_mode,
    input  logic             rd_tick,
    input  logic             wr_done,
    input  logic             mem_bit,
    output logic [AW-1:0]    mem_addr,
    output logic [POS_W-1:0] pos,
    output logic             slot,
    output logic             nx_bit,
    output logic             nx_frame,
    output logic             nx_mframe,
    output slip_e            slip_kind
);
    localparam int WIDE_BITS = WIDE_SLOTS * SLOT_BITS;
    localparam int MF_W      = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;

    logic [MF_W-1:0]  mf;
    logic [1:0]       pend;
    logic [1:0]       pend_sum;
    logic [POS_W-1:0] last_pos;
    logic             at_end;
    logic             filler;
    int               ts_i;
    int               bit_i;
    int               idx_i;

    // Map the output position to a stored bit, or mark it as filler.
    always_comb begin
        ts_i   = int'(pos) / SLOT_BITS;
        bit_i  = int'(pos) % SLOT_BITS;
        filler = wide_mode && ((ts_i % FILL_PERIOD) == 0);
        if (!wide_mode) begin
            idx_i = int'(pos);
        end else if (filler) begin
            idx_i = 0;
        end else begin
            idx_i = 1 + (ts_i - ts_i / FILL_PERIOD - 1) * SLOT_BITS + bit_i;
        end
        mem_addr = AW'(slot ? idx_i + FRAME_BITS : idx_i);
    end

    // Form the next output bit and pulses for the current position.
    always_comb begin
        nx_bit    = (filler && !(ts_i == 0 && bit_i == 0)) ? 1'b1 : mem_bit;
        nx_frame  = rd_tick && (pos == '0);
        nx_mframe = rd_tick && (pos == '0) && (mf == '0);
    end

    // Frame-level slip decision from the pending-frame count.
    always_comb begin
        last_pos  = wide_mode ? POS_W'(WIDE_BITS - 1) : POS_W'(FRAME_BITS - 1);
        at_end    = rd_tick && (pos == last_pos);
        pend_sum  = (pend == 2'd2) ? 2'd2 : pend + {1'b0, wr_done};
        slip_kind = SLIP_NONE;
        if (at_end && pend_sum == 2'd0) slip_kind = SLIP_REPEAT;
        if (at_end && pend_sum == 2'd2) slip_kind = SLIP_DROP;
    end

    // Advance position, choose the next frame area and track pending frames.
    always_ff @(posedge clk) begin
        if (!rst_n || store_rst) begin
            pos  <= '0;
            slot <= 1'b1;
            mf   <= '0;
            pend <= 2'd0;
        end else if (at_end) begin
            pos  <= '0;
            mf   <= (mf == MF_W'(MF_FRAMES - 1)) ? '0 : mf + MF_W'(1);
            slot <= (pend_sum == 2'd1) ? ~slot : slot;
            pend <= 2'd0;
        end else begin
            if (rd_tick) pos <= pos + POS_W'(1);
            pend <= pend_sum;
        end
    end
endmodule

// File: rtl/t1_elastic_store.sv
`timescale 1ns/1ps
// Top of the T1 two-frame elastic store: write pointer, bit store, read side,
// pass-through path, output register and sticky slip flags.
// Assumes wr_valid and rd_tick are enables of clk, at most one bit per cycle each.
module t1_elastic_store
    import t1es_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int WIDE_SLOTS = 32,
    parameter int MF_FRAMES  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_en,
    input  logic wide_mode,
    input  logic store_rst,
    input  logic wr_valid,
    input  logic wr_bit,
    input  logic rd_tick,
    input  logic clr_under,
    input  logic clr_over,
    output logic rd_valid,
    output logic rd_bit,
    output logic rd_frame_pulse,
    output logic rd_mframe_pulse,
    output logic slip_under,
    output logic slip_over
);
    localparam int AW      = $clog2(2 * FRAME_BITS);
    localparam int OUT_MAX = (WIDE_SLOTS * SLOT_BITS > FRAME_BITS) ?
                             WIDE_SLOTS * SLOT_BITS : FRAME_BITS;
    localparam int POS_W   = $clog2(OUT_MAX);

    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic [POS_W-1:0] rd_pos;
    logic             wr_done;
    logic             wr_frame_start;
    logic             wr_slot;
    logic             rd_slot;
    logic             mem_bit;
    logic             nx_bit;
    logic             nx_frame;
    logic             nx_mframe;
    slip_e            slip_kind;

    t1es_writer #(.FRAME_BITS(FRAME_BITS), .AW(AW)) u_writer (
        .clk(clk), .rst_n(rst_n), .store_rst(store_rst), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_done(wr_done), .wr_frame_start(wr_frame_start),
        .wr_slot(wr_slot)
    );

    t1es_bitram #(.FRAME_BITS(FRAME_BITS), .AW(AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(wr_valid), .waddr(wr_addr), .wdata(wr_bit),
        .raddr(rd_addr), .rdata(mem_bit)
    );

    t1es_reader #(
        .FRAME_BITS(FRAME_BITS), .WIDE_SLOTS(WIDE_SLOTS), .MF_FRAMES(MF_FRAMES),
        .AW(AW), .POS_W(POS_W)
    ) u_reader (
        .clk(clk), .rst_n(rst_n), .store_rst(store_rst), .wide_mode(wide_mode),
        .rd_tick(rd_tick), .wr_done(wr_done), .mem_bit(mem_bit),
        .mem_addr(rd_addr), .pos(rd_pos), .slot(rd_slot), .nx_bit(nx_bit),
        .nx_frame(nx_frame), .nx_mframe(nx_mframe), .slip_kind(slip_kind)
    );

    // Register the output from either the store or the pass-through path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid        <= 1'b0;
            rd_bit          <= 1'b0;
            rd_frame_pulse  <= 1'b0;
            rd_mframe_pulse <= 1'b0;
        end else if (store_en) begin
            rd_valid        <= rd_tick;
            rd_bit          <= nx_bit;
            rd_frame_pulse  <= nx_frame;
            rd_mframe_pulse <= nx_mframe;
        end else begin
            rd_valid        <= wr_valid;
            rd_bit          <= wr_bit;
            rd_frame_pulse  <= wr_valid && wr_frame_start;
            rd_mframe_pulse <= 1'b0;
        end
    end

    // Sticky slip flags: set on a slip, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip_under <= 1'b0;
            slip_over  <= 1'b0;
        end else begin
            slip_under <= (store_en && slip_kind == SLIP_REPEAT) || (slip_under && !clr_under);
            slip_over  <= (store_en && slip_kind == SLIP_DROP)   || (slip_over  && !clr_over);
        end
    end
endmodule

// File: rtl/t1es_checker.sv
`timescale 1ns/1ps
// Property checker for the elastic store, bound to the top module.
// Observes ports plus the pointer areas and output position of the top.
module t1es_checker #(
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             store_en,
    input logic             wide_mode,
    input logic             store_rst,
    input logic             wr_valid,
    input logic             rd_tick,
    input logic             clr_under,
    input logic             clr_over,
    input logic             rd_valid,
    input logic             rd_bit,
    input logic             rd_frame_pulse,
    input logic             rd_mframe_pulse,
    input logic             slip_under,
    input logic             slip_over,
    input logic [POS_W-1:0] rd_pos,
    input logic             rd_slot,
    input logic             wr_slot
);
    // R3: a repeat slip only appears after a read tick.
    p_under_at_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slip_under) |-> $past(rd_tick));

    // R4: a drop slip only appears after a read tick.
    p_over_at_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slip_over) |-> $past(rd_tick));

    // R5: store reset leaves the pointers in opposite frame areas.
    p_opposite_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_rst |=> (rd_slot != wr_slot));

    // R6: filler timeslots output ones, except the framing bit position.
    p_filler_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && wide_mode && rd_tick && ((int'(rd_pos) / 8) % 4 == 0)
         && (int'(rd_pos) % 8 != 0)) |=> rd_bit);

    // R8: no multiframe pulse while passing through.
    p_no_mframe_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !store_en |=> !rd_mframe_pulse);

    // R9: a multiframe pulse is also a frame pulse.
    p_mframe_is_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mframe_pulse |-> rd_frame_pulse);

    // R10: slip flags hold until cleared.
    p_under_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_under && !clr_under) |=> slip_under);
    p_over_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_over && !clr_over) |=> slip_over);

    // R11: a read tick in store mode yields a valid bit next cycle.
    p_tick_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && rd_tick) |=> rd_valid);
    p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_tick && !wr_valid) |=> !rd_valid);
endmodule

bind t1_elastic_store t1es_checker #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .wide_mode(wide_mode),
    .store_rst(store_rst), .wr_valid(wr_valid), .rd_tick(rd_tick),
    .clr_under(clr_under), .clr_over(clr_over), .rd_valid(rd_valid),
    .rd_bit(rd_bit), .rd_frame_pulse(rd_frame_pulse),
    .rd_mframe_pulse(rd_mframe_pulse), .slip_under(slip_under),
    .slip_over(slip_over), .rd_pos(rd_pos), .rd_slot(rd_slot), .wr_slot(wr_slot)
);

// File: tb/t1_elastic_store_test.sv
`timescale 1ns/1ps
// Self-checking bench: random strobe rates and data from a fixed seed, plus
// directed slip, clear and reset cases, compared against a cycle model.
module t1_elastic_store_test;
    localparam int FB = 193;
    localparam int DEPTH = 2 * FB;

    logic clk = 1'b0;
    logic rst_n, store_en, wide_mode, store_rst, wr_valid, wr_bit, rd_tick;
    logic clr_under, clr_over;
    logic rd_valid, rd_bit, rd_frame_pulse, rd_mframe_pulse, slip_under, slip_over;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    string cur_req = "R2";

    // Model state
    bit m_mem [DEPTH];
    int m_wa, m_pos, m_mf, m_d;
    bit m_slot, m_under, m_over;
    bit e_valid, e_bit, e_frame, e_mframe;
    string bit_req;

    always #2.5 clk = ~clk;

    t1_elastic_store uut (
        .clk(clk), .rst_n(rst_n), .store_en(store_en), .wide_mode(wide_mode),
        .store_rst(store_rst), .wr_valid(wr_valid), .wr_bit(wr_bit),
        .rd_tick(rd_tick), .clr_under(clr_under), .clr_over(clr_over),
        .rd_valid(rd_valid), .rd_bit(rd_bit), .rd_frame_pulse(rd_frame_pulse),
        .rd_mframe_pulse(rd_mframe_pulse), .slip_under(slip_under),
        .slip_over(slip_over)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected output bit for a position, from R2, R6 and R7.
    function automatic bit model_bit(input int pos);
        int base = m_slot ? FB : 0;
        int ts = pos / 8;
        int b = pos % 8;
        if (!wide_mode) return m_mem[base + pos];
        if (ts % 4 == 0) return (ts == 0 && b == 0) ? m_mem[base] : 1'b1;
        return m_mem[base + 1 + (ts - ts / 4 - 1) * 8 + b];
    endfunction

    function automatic string model_req(input int pos);
        if (!store_en) return "R8";
        if (!wide_mode) return cur_req;
        return ((pos / 8) % 4 == 0) ? "R6" : "R7";
    endfunction

    task automatic model_reset();
        foreach (m_mem[i]) m_mem[i] = 1'b0;
        m_wa = 0; m_pos = 0; m_mf = 0; m_d = 0;
        m_slot = 1'b1; m_under = 1'b0; m_over = 1'b0;
    endtask

    // One clock cycle: drive, advance model, sample one ns after the edge.
    task automatic cycle(input bit wv, input bit wb, input bit rt, input bit srst,
                         input bit cu, input bit co);
        int last;
        int dsum;
        bit wdone, at_end, under, over;
        wr_valid = wv; wr_bit = wb; rd_tick = rt; store_rst = srst;
        clr_under = cu; clr_over = co;
        last  = wide_mode ? 255 : FB - 1;
        wdone = wv && (m_wa == FB - 1 || m_wa == DEPTH - 1);
        if (store_en) begin
            e_valid = rt; e_bit = model_bit(m_pos); bit_req = model_req(m_pos);
            e_frame = rt && m_pos == 0; e_mframe = rt && m_pos == 0 && m_mf == 0;
        end else begin
            e_valid = wv; e_bit = wb; bit_req = "R8";
            e_frame = wv && (m_wa == 0 || m_wa == FB); e_mframe = 1'b0;
        end
        dsum   = (m_d + int'(wdone) > 2) ? 2 : m_d + int'(wdone);
        at_end = rt && m_pos == last;
        under  = at_end && dsum == 0;
        over   = at_end && dsum == 2;
        if (srst) begin
            m_pos = 0; m_slot = 1'b1; m_mf = 0; m_d = 0;
        end else if (at_end) begin
            m_pos = 0; m_mf = (m_mf == 11) ? 0 : m_mf + 1;
            if (dsum == 1) m_slot = ~m_slot;
            m_d = 0;
        end else begin
            if (rt) m_pos++;
            m_d = dsum;
        end
        if (store_en && under) m_under = 1'b1; else if (cu) m_under = 1'b0;
        if (store_en && over)  m_over  = 1'b1; else if (co) m_over  = 1'b0;
        if (wv) m_mem[m_wa] = wb;
        if (srst) m_wa = 0; else if (wv) m_wa = (m_wa == DEPTH - 1) ? 0 : m_wa + 1;
        @(posedge clk); #1;
        check(rd_valid === e_valid, store_en ? "R11" : "R8", int'(rd_valid), int'(e_valid));
        if (e_valid) begin
            check(rd_bit === e_bit, bit_req, int'(rd_bit), int'(e_bit));
            check({rd_frame_pulse, rd_mframe_pulse} === {e_frame, e_mframe},
                  store_en ? "R9" : "R8",
                  int'({rd_frame_pulse, rd_mframe_pulse}), int'({e_frame, e_mframe}));
        end
        check({slip_under, slip_over} === {m_under, m_over}, "R10",
              int'({slip_under, slip_over}), int'({m_under, m_over}));
    endtask

    task automatic run(input int n, input int w_pct, input int r_pct);
        for (int i = 0; i < n; i++) begin
            cycle(($urandom % 100) < w_pct, $urandom % 2, ($urandom % 100) < r_pct,
                  1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; store_en = 1'b1; wide_mode = 1'b0; store_rst = 1'b0;
        wr_valid = 1'b0; wr_bit = 1'b0; rd_tick = 1'b0; clr_under = 1'b0; clr_over = 1'b0;
        model_reset();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            // R1: outputs and flags low during reset
            check({rd_valid, rd_frame_pulse, rd_mframe_pulse, slip_under, slip_over} === 5'b0,
                  "R1", int'({rd_valid, rd_frame_pulse, rd_mframe_pulse, slip_under, slip_over}), 0);
        end
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // R1: first tick reads zeros
        check(rd_bit === 1'b0, "R1", int'(rd_bit), 0);

        // R5: store reset, then equal rates; frame area 1 read first
        cur_req = "R5";
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(2 * FB, 100, 100);
        // R2: steady equal rates and a mildly bursty phase
        cur_req = "R2";
        run(4 * FB, 100, 100);
        run(1500, 80, 80);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check({slip_under, slip_over} === 2'b00, "R10", int'({slip_under, slip_over}), 0);

        // R3: reader twice as fast as writer must repeat frames
        cur_req = "R3";
        run(2000, 50, 100);
        check(slip_under === 1'b1, "R3", int'(slip_under), 1);
        check(slip_over === 1'b0, "R3", int'(slip_over), 0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(slip_under === 1'b0, "R10", int'(slip_under), 0);

        // R4: writer three times as fast as reader must drop frames
        cur_req = "R4";
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(2500, 100, 33);
        check(slip_over === 1'b1, "R4", int'(slip_over), 1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

        // R6 and R7: wide output frames
        wide_mode = 1'b1;
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(4000, 76, 100);

        // R8: pass-through
        store_en = 1'b0;
        run(900, 60, 50);
        store_en = 1'b1;

        // Random segments over modes and rates (R2, R3, R4, R6, R7, R9, R10)
        cur_req = "R2";
        for (int s = 0; s < 8; s++) begin
            wide_mode = $urandom % 2;
            cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            run(2000, 30 + $urandom % 71, 30 + $urandom % 71);
            cycle(1'b0, 1'b0, 1'b0, 1'b0, $urandom % 2, $urandom % 2);
        end
        finish_run();
    end
endmodule